// File: doc/BRIEF.md
# Keyed Configuration Port Decoder

This block is the configuration front end of a multi-function peripheral controller. It takes two byte-wide I/O ports. The index port sits at a base address and the data port sits one address above it. The base is one of two strap-selected addresses, 0x2E or 0x4E. After reset the configuration space is hidden. The host opens it by writing an unlock key to the index port twice in a row, and closes it again with a lock key. A strap input picks an alternate key pair, so that a companion device can share the same two ports without answering to the same keys.

While the space is open, the host writes a register index to the index port, then reads or writes that register through the data port. Two indexes are global: a logical-device selector and a fixed chip identifier. Every index from 0x30 upward belongs to the bank of the logical device that the selector names. Logical device 8 is the watchdog bank. For those indexes the block raises a one-hot device select together with a read or write strobe, and forwards the index and the write byte, all in the same bus cycle. It returns the selected device's read byte in that same cycle.

Top module: `cfg_port_decoder`

## Requirements
- R1: After reset the block is locked, the selector and the index hold 0x00, no device strobe is asserted, and reads of either port return 0xFF.
- R2: Two index-port writes of the unlock key in consecutive accesses open the space (default key 0x87). While open, a read of the index port returns the last index written.
- R3: Between the two unlock writes, any other index-port write or any data-port read or write aborts the sequence. A single further unlock write then leaves the block locked.
- R4: While open, an index-port write of the lock key (default 0xAA) relocks the space. That byte is not stored as the index, so after the next unlock the index port reads back the previous index.
- R5: With alt_key=1 the unlock key is 0x88 and the lock key is 0xBB. The default bytes then have no key function: 0x87 does not unlock, and 0xAA written while open is stored as an index.
- R6: With base_sel=0 the ports are 0x2E (index) and 0x2F (data). With base_sel=1 they are 0x4E and 0x4F. An access to any other address raises no strobe, changes no state and reads 0xFF.
- R7: While locked, data-port writes are ignored: no device strobe, and the selector is unchanged. Reads of either port return 0xFF.
- R8: Index 0x07 is the logical-device selector. It can be read and written through the data port and resets to 0x00.
- R9: Index 0x20 reads the fixed chip identifier (parameter CHIP_ID, default 0xA7). Writes to it are ignored.
- R10: For an index of 0x30 or more with selector value n below NUM_DEV (default 9), a data-port access asserts bit n of dev_sel together with dev_wr or dev_rd in the same cycle. dev_idx carries the index and dev_wdata the write byte. A read returns dev_rdata bits [8n+7:8n].
- R11: When the selector is NUM_DEV or more, forwarded indexes raise no strobe and read 0xFF. Indexes below 0x30 other than 0x07 and 0x20 read 0x00.
- R12: A data-port access with bus_rd and bus_wr both high performs the write. The read returns the register's value from before that write. For a forwarded index, dev_rd and dev_wr are both asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_sel | input | 1 | Base address strap: 0 selects 0x2E, 1 selects 0x4E |
| alt_key | input | 1 | Key pair strap: 0 selects 0x87/0xAA, 1 selects 0x88/0xBB |
| bus_addr | input | 16 | I/O address of the current access |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid in the cycle of bus_rd |
| dev_sel | output | 9 | One-hot logical device select, one bit per device |
| dev_idx | output | 8 | Current register index forwarded to devices |
| dev_wdata | output | 8 | Write byte forwarded to devices |
| dev_wr | output | 1 | Forwarded write strobe |
| dev_rd | output | 1 | Forwarded read strobe |
| dev_rdata | input | 72 | Read bytes of all devices, device n at bits [8n+7:8n] |

## Verification
A read and a write can land on the same data-port register in one cycle when the host raises both strobes together. The bench provokes this twice. On the selector, the read must return the old selector value, and the next plain read must return the new one. On a forwarded index, both device strobes must rise with the select bit of the current device. Key handling is judged the same way. A data-port access wedged between the two unlock writes must leave the following data read at 0xFF.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_ARMED  = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_e;

  localparam logic [7:0] SEL_INDEX = 8'h07;
  localparam logic [7:0] ID_INDEX  = 8'h20;
  localparam logic [7:0] FWD_INDEX = 8'h30;
  localparam logic [7:0] IDLE_BYTE = 8'hFF;
endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode #(
  parameter int                ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_A = 16'h002E,
  parameter logic [ADDR_W-1:0] BASE_B = 16'h004E
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              base_sel,
  input  logic              wr,
  input  logic              rd,
  output logic              idx_hit,
  output logic              idx_wr,
  output logic              idx_rd,
  output logic              dat_wr,
  output logic              dat_rd
);
  logic [ADDR_W-1:0] base;
  logic              dat_hit;

  always_comb begin
    base    = base_sel ? BASE_B : BASE_A;
    idx_hit = (addr == base);
    dat_hit = (addr == base + ADDR_W'(1));
    idx_wr  = idx_hit & wr;
    idx_rd  = idx_hit & rd;
    dat_wr  = dat_hit & wr;
    dat_rd  = dat_hit & rd;
  end
endmodule

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
  import cfg_pkg::*;
#(
  parameter logic [7:0] UNLOCK_A = 8'h87,
  parameter logic [7:0] LOCK_A   = 8'hAA,
  parameter logic [7:0] UNLOCK_B = 8'h88,
  parameter logic [7:0] LOCK_B   = 8'hBB
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       alt_key,
  input  logic       idx_wr,
  input  logic       dat_acc,
  input  logic [7:0] wdata,
  output logic       unlocked,
  output logic       idx_load
);
  key_state_e state_q, state_d;
  logic [7:0] unlock_key, lock_key;

  always_comb begin
    unlock_key = alt_key ? UNLOCK_B : UNLOCK_A;
    lock_key   = alt_key ? LOCK_B   : LOCK_A;
    state_d    = state_q;
    unique case (state_q)
      KS_LOCKED: if (idx_wr && wdata == unlock_key) state_d = KS_ARMED;
      KS_ARMED: begin
        if (idx_wr)       state_d = (wdata == unlock_key) ? KS_OPEN : KS_LOCKED;
        else if (dat_acc) state_d = KS_LOCKED;
      end
      KS_OPEN:   if (idx_wr && wdata == lock_key) state_d = KS_LOCKED;
      default:   state_d = KS_LOCKED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KS_LOCKED;
    else        state_q <= state_d;
  end

  assign unlocked = (state_q == KS_OPEN);
  assign idx_load = unlocked & idx_wr & (wdata != lock_key);
endmodule

// File: rtl/cfg_bank_regs.sv
module cfg_bank_regs
  import cfg_pkg::*;
#(
  parameter int         NUM_DEV = 9,
  parameter logic [7:0] CHIP_ID = 8'hA7,
  localparam int        RD_W    = 8 * NUM_DEV
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               unlocked,
  input  logic               idx_load,
  input  logic [7:0]         wdata,
  input  logic               dat_wr,
  input  logic               dat_rd,
  input  logic [RD_W-1:0]    dev_rdata,
  output logic [7:0]         index_q,
  output logic [NUM_DEV-1:0] dev_sel,
  output logic               dev_wr,
  output logic               dev_rd,
  output logic [7:0]         dat_rdata
);
  logic [7:0] ldn_q, ldn_d, index_d, dev_byte;
  logic       ldn_en, fwd, ldn_ok, acc_ok;

  always_comb begin
    index_d = wdata;
    ldn_d   = wdata;
    ldn_en  = unlocked & dat_wr & (index_q == SEL_INDEX);
    fwd     = (index_q >= FWD_INDEX);
    ldn_ok  = (ldn_q < 8'(NUM_DEV));
    acc_ok  = unlocked & fwd & ldn_ok;
    dev_wr  = acc_ok & dat_wr;
    dev_rd  = acc_ok & dat_rd;
  end

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_sel
    assign dev_sel[g] = acc_ok & (dat_wr | dat_rd) & (ldn_q == 8'(g));
  end

  always_comb begin
    dev_byte = IDLE_BYTE;
    for (int i = 0; i < NUM_DEV; i++) begin
      if (ldn_q == 8'(i)) dev_byte = dev_rdata[8*i +: 8];
    end
  end

  always_comb begin
    if (!unlocked)               dat_rdata = IDLE_BYTE;
    else if (index_q == SEL_INDEX) dat_rdata = ldn_q;
    else if (index_q == ID_INDEX)  dat_rdata = CHIP_ID;
    else if (fwd)                  dat_rdata = dev_byte;
    else                           dat_rdata = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_q <= 8'h00;
      ldn_q   <= 8'h00;
    end else begin
      if (idx_load) index_q <= index_d;
      if (ldn_en)   ldn_q   <= ldn_d;
    end
  end
endmodule

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder
  import cfg_pkg::*;
#(
  parameter int         ADDR_W   = 16,
  parameter int         NUM_DEV  = 9,
  parameter logic [7:0] CHIP_ID  = 8'hA7,
  parameter logic [7:0] UNLOCK_A = 8'h87,
  parameter logic [7:0] LOCK_A   = 8'hAA,
  parameter logic [7:0] UNLOCK_B = 8'h88,
  parameter logic [7:0] LOCK_B   = 8'hBB,
  localparam int        RD_W     = 8 * NUM_DEV
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               base_sel,
  input  logic               alt_key,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  output logic [NUM_DEV-1:0] dev_sel,
  output logic [7:0]         dev_idx,
  output logic [7:0]         dev_wdata,
  output logic               dev_wr,
  output logic               dev_rd,
  input  logic [RD_W-1:0]    dev_rdata
);
  logic       rst_sync_n;
  logic       idx_hit, idx_wr, idx_rd, dat_wr, dat_rd;
  logic       unlocked, idx_load;
  logic [7:0] index_q, dat_rdata;

  cfg_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  cfg_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .base_sel(base_sel), .wr(bus_wr), .rd(bus_rd),
    .idx_hit(idx_hit), .idx_wr(idx_wr), .idx_rd(idx_rd),
    .dat_wr(dat_wr), .dat_rd(dat_rd)
  );

  cfg_key_fsm #(
    .UNLOCK_A(UNLOCK_A), .LOCK_A(LOCK_A), .UNLOCK_B(UNLOCK_B), .LOCK_B(LOCK_B)
  ) u_key (
    .clk(clk), .rst_n(rst_sync_n), .alt_key(alt_key), .idx_wr(idx_wr),
    .dat_acc(dat_wr | dat_rd), .wdata(bus_wdata),
    .unlocked(unlocked), .idx_load(idx_load)
  );

  cfg_bank_regs #(.NUM_DEV(NUM_DEV), .CHIP_ID(CHIP_ID)) u_bank (
    .clk(clk), .rst_n(rst_sync_n), .unlocked(unlocked), .idx_load(idx_load),
    .wdata(bus_wdata), .dat_wr(dat_wr), .dat_rd(dat_rd), .dev_rdata(dev_rdata),
    .index_q(index_q), .dev_sel(dev_sel), .dev_wr(dev_wr), .dev_rd(dev_rd),
    .dat_rdata(dat_rdata)
  );

  assign dev_idx   = index_q;
  assign dev_wdata = bus_wdata;

  always_comb begin
    if (idx_rd)      bus_rdata = unlocked ? index_q : IDLE_BYTE;
    else if (dat_rd) bus_rdata = dat_rdata;
    else             bus_rdata = IDLE_BYTE;
  end
endmodule

// File: rtl/cfg_port_decoder_chk.sv
module cfg_port_decoder_chk #(
  parameter int         NUM_DEV = 9,
  parameter logic [7:0] LOCK_A  = 8'hAA,
  parameter logic [7:0] LOCK_B  = 8'hBB
) (
  input logic               clk,
  input logic               rst_n,
  input logic               alt_key,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [7:0]         bus_wdata,
  input logic [7:0]         bus_rdata,
  input logic [NUM_DEV-1:0] dev_sel,
  input logic               dev_wr,
  input logic               dev_rd,
  input logic               unlocked,
  input logic               idx_hit
);
  a_r10_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_sel));

  a_r10_wr_from_bus: assert property (@(posedge clk) disable iff (!rst_n)
    dev_wr |-> bus_wr && dev_sel != '0);

  a_r10_rd_from_bus: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rd |-> bus_rd && dev_sel != '0);

  a_r7_no_strobe_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |-> !dev_wr && !dev_rd && dev_sel == '0);

  a_r7_idle_read_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && bus_rd) |-> bus_rdata == 8'hFF);

  a_r2_open_after_index_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(bus_wr && idx_hit));

  a_r4_lock_key_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && bus_wr && idx_hit && bus_wdata == (alt_key ? LOCK_B : LOCK_A))
      |=> !unlocked);
endmodule

bind cfg_port_decoder cfg_port_decoder_chk #(
  .NUM_DEV(NUM_DEV), .LOCK_A(LOCK_A), .LOCK_B(LOCK_B)
) u_chk (.*);

// File: tb/tb_cfg_port_decoder.sv
module tb_cfg_port_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int NDEV       = 9;
  localparam logic [7:0] CHIP = 8'hA7;

  typedef struct {
    int          kind;
    logic [15:0] exp;
    string       req;
  } item_t;

  logic              clk, rst_n, base_sel, alt_key, bus_wr, bus_rd;
  logic [15:0]       bus_addr;
  logic [7:0]        bus_wdata, bus_rdata, dev_idx, dev_wdata;
  logic [NDEV-1:0]   dev_sel;
  logic              dev_wr, dev_rd;
  logic [8*NDEV-1:0] dev_rdata;

  item_t q[$];
  int    n_checks = 0;
  int    n_errors = 0;
  bit    done     = 0;

  cfg_port_decoder dut (
    .clk(clk), .rst_n(rst_n), .base_sel(base_sel), .alt_key(alt_key),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_sel(dev_sel),
    .dev_idx(dev_idx), .dev_wdata(dev_wdata), .dev_wr(dev_wr),
    .dev_rd(dev_rd), .dev_rdata(dev_rdata)
  );

  // device model: device n answers {n, low nibble of index}
  always_comb begin
    for (int i = 0; i < NDEV; i++) dev_rdata[8*i +: 8] = {4'(i), dev_idx[3:0]};
  end

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] st(input logic w, input logic r, input int dev);
    logic [15:0] v = '0;
    v[NDEV+1] = w;
    v[NDEV]   = r;
    if (dev >= 0) v[dev] = 1'b1;
    return v;
  endfunction

  task automatic acc(input logic [15:0] a, input logic w, input logic r,
                     input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
  endtask

  task automatic expect_item(input int kind, input logic [15:0] e, input string req);
    item_t it;
    it.kind = kind; it.exp = e; it.req = req;
    q.push_back(it);
  endtask

  // monitor: compares every item pushed in this cycle, a quarter period after the drive
  always begin
    @(negedge clk);
    #(CLK_PERIOD/4);
    while (q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = q.pop_front();
      case (it.kind)
        0:       act = {8'h00, bus_rdata};
        1:       act = {5'b0, dev_wr, dev_rd, dev_sel};
        default: act = {dev_idx, dev_wdata};
      endcase
      n_checks++;
      if (act !== it.exp) begin
        n_errors++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; base_sel = 1'b0; alt_key = 1'b0;
    bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    acc(16'h2F, 0, 1, 8'h00); expect_item(0, 16'h00FF, "R1"); expect_item(1, st(0,0,-1), "R1");
    acc(16'h2E, 0, 1, 8'h00); expect_item(0, 16'h00FF, "R1");

    // R7 locked writes ignored
    acc(16'h2F, 1, 0, 8'h55); expect_item(1, st(0,0,-1), "R7");

    // R3 broken sequences
    acc(16'h2E, 1, 0, 8'h87);
    acc(16'h2F, 0, 1, 8'h00); expect_item(0, 16'h00FF, "R3");
    acc(16'h2E, 1, 0, 8'h87);
    acc(16'h2F, 0, 1, 8'h00); expect_item(0, 16'h00FF, "R3");
    acc(16'h2E, 1, 0, 8'h87);
    acc(16'h2E, 1, 0, 8'h55);
    acc(16'h2E, 1, 0, 8'h87);
    acc(16'h2F, 0, 1, 8'h00); expect_item(0, 16'h00FF, "R3");

    // R2 unlock, R8 selector reset value
    acc(16'h2E, 1, 0, 8'h87);
    acc(16'h2E, 1, 0, 8'h87);
    acc(16'h2E, 1, 0, 8'h07);
    acc(16'h2F, 0, 1, 8'h00); expect_item(0, 16'h0000, "R8");
    acc(16'h2E, 0, 1, 8'h00); expect_item(0, 16'h0007, "R2");
    acc(16'h2F, 1, 0, 8'h03);
    acc(16'h2F, 0, 1, 8'h00); expect_item(0, 16'h0003, "R8");

    // R9 chip identifier
    acc(16'h2E, 1, 0, 8'h20);
    acc(16'h2F, 0, 1, 8'h00); expect_item(0, {8'h00, CHIP}, "R9");
    acc(16'h2F, 1, 0, 8'h11); expect_item(1, st(0,0,-1), "R9");
    acc(16'h2F, 0, 1, 8'h00); expect_item(0, {8'h00, CHIP}, "R9");

    // R11 reserved global index
    acc(16'h2E, 1, 0, 8'h25);
    acc(16'h2F, 0, 1, 8'h00); expect_item(0, 16'h0000, "R11");

    // R10 forwarding to the watchdog bank (device 8)
    acc(16'h2E, 1, 0, 8'h07);
    acc(16'h2F, 1, 0, 8'h08);
    acc(16'h2E, 1, 0, 8'h35);
    acc(16'h2F, 0, 1, 8'h00); expect_item(0, 16'h0085, "R10"); expect_item(1, st(0,1,8), "R10");
    acc(16'h2F, 1, 0, 8'h5A); expect_item(1, st(1,0,8), "R10"); expect_item(2, 16'h355A, "R10");

    // R12 simultaneous read and write
    acc(16'h2E, 1, 0, 8'h07);
    acc(16'h2F, 1, 1, 8'h02); expect_item(0, 16'h0008, "R12");
    acc(16'h2F, 0, 1, 8'h00); expect_item(0, 16'h0002, "R12");
    acc(16'h2E, 1, 0, 8'h31);
    acc(16'h2F, 1, 1, 8'h77); expect_item(0, 16'h0021, "R12"); expect_item(1, st(1,1,2), "R12");

    // R11 selector out of range
    acc(16'h2E, 1, 0, 8'h07);
    acc(16'h2F, 1, 0, 8'h0C);
    acc(16'h2E, 1, 0, 8'h30);
    acc(16'h2F, 0, 1, 8'h00); expect_item(0, 16'h00FF, "R11"); expect_item(1, st(0,0,-1), "R11");

    // R4 lock key, index preserved
    acc(16'h2E, 1, 0, 8'hAA);
    acc(16'h2F, 0, 1, 8'h00); expect_item(0, 16'h00FF, "R4");
    acc(16'h2E, 0, 1, 8'h00); expect_item(0, 16'h00FF, "R4");
    acc(16'h2E, 1, 0, 8'h87);
    acc(16'h2E, 1, 0, 8'h87);
    acc(16'h2E, 0, 1, 8'h00); expect_item(0, 16'h0030, "R4");

    // R6 alternate base
    acc(16'h2E, 0, 0, 8'h00);
    base_sel = 1'b1;
    acc(16'h2E, 0, 1, 8'h00); expect_item(0, 16'h00FF, "R6");
    acc(16'h2F, 1, 0, 8'h44); expect_item(1, st(0,0,-1), "R6");
    acc(16'h4E, 0, 1, 8'h00); expect_item(0, 16'h0030, "R6");
    acc(16'h4E, 1, 0, 8'h07);
    acc(16'h4F, 1, 0, 8'h01);
    acc(16'h4E, 1, 0, 8'h33);
    acc(16'h4F, 0, 1, 8'h00); expect_item(0, 16'h0013, "R6"); expect_item(1, st(0,1,1), "R6");
    acc(16'h4E, 1, 0, 8'hAA);

    // R5 alternate key pair
    acc(16'h4E, 0, 0, 8'h00);
    alt_key = 1'b1;
    acc(16'h4E, 1, 0, 8'h87);
    acc(16'h4E, 1, 0, 8'h87);
    acc(16'h4E, 0, 1, 8'h00); expect_item(0, 16'h00FF, "R5");
    acc(16'h4E, 1, 0, 8'h88);
    acc(16'h4E, 1, 0, 8'h88);
    acc(16'h4E, 0, 1, 8'h00); expect_item(0, 16'h0033, "R5");
    acc(16'h4E, 1, 0, 8'hAA);
    acc(16'h4E, 0, 1, 8'h00); expect_item(0, 16'h00AA, "R5");
    acc(16'h4E, 1, 0, 8'hBB);
    acc(16'h4E, 0, 1, 8'h00); expect_item(0, 16'h00FF, "R5");

    acc(16'h0000, 0, 0, 8'h00);
    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule